// File: doc/BRIEF.md
# Conversion Auto-Trigger Source Selector

This block sits in front of a converter's conversion sequencer. It chooses one of eight trigger sources with a 3-bit code. It watches the chosen level for a low-to-high change and turns each such change into a one-clock start request. Seven of the sources are flag lines from other blocks, such as a comparator, an external interrupt and timers. The eighth is the converter's own completion flag. Selecting the completion flag makes conversions follow one another without a gap.

Edge detection happens after the selection multiplexer. Switching the selection from a source that is low to a source that is high is therefore seen as a rising edge. The one exception is a switch into the free-running code: on that cycle the edge is suppressed, even when the completion flag is already high. A start request is only issued when automatic triggering is on, the converter is enabled and the sequencer is not busy. A request that is refused is dropped and is not held for later.

Top module: `adc_trig_select`

## Requirements
- R1: `trig_level` follows the selected source without a clock delay. Code 0 selects `conv_done`. Code k, for k from 1 to 7, selects `ext_flags[k-1]`: 1 comparator, 2 external interrupt 0, 3 timer 0 compare A, 4 timer 0 overflow, 5 timer 1 compare B, 6 timer 1 overflow, 7 timer 1 capture.
- R2: While `auto_en` is low, `start_pulse` stays low whatever `src_sel` and the source levels do.
- R3: When the selected level is low at one rising clock edge and high at the next, `start_pulse` is high for the clock cycle that follows that second edge. This holds only when R2, R6 and R9 permit a start.
- R4: A change of `src_sel` from a source that is low to a source that is high counts as a rising edge under R3.
- R5: On the cycle where `src_sel` changes to code 0 from another code, no start is issued, even if `conv_done` is high.
- R6: While `conv_en` is low, no start is issued.
- R7: With code 0 selected, each rising edge of `conv_done` issues a start, so conversions run back to back.
- R8: `start_pulse` is never high for two cycles in a row.
- R9: An edge sampled while `busy` is high issues no start. It is not replayed when `busy` falls.
- R10: During reset `start_pulse` is low. A selected level that is already high at the first clock after reset issues no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_en | input | 1 | Automatic triggering on |
| conv_en | input | 1 | Converter enabled |
| busy | input | 1 | Sequencer is converting |
| src_sel | input | 3 | Trigger source code |
| ext_flags | input | 7 | Flag lines for codes 1 to 7 |
| conv_done | input | 1 | Converter completion flag (code 0) |
| start_pulse | output | 1 | One-cycle conversion start request |
| trig_level | output | 1 | Currently selected trigger level |

## Verification
A wrong previous-level register shows up as a missing or extra `start_pulse` one clock after the offending edge. A stuck-high register also breaks the single-cycle property. If the free-running entry guard is wrong, a spurious start appears on the cycle right after the switch into code 0 while `conv_done` is high. A mux decode error is visible on `trig_level` at once, in the same cycle.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int unsigned NUM_EXT = 7;
    localparam int unsigned SEL_W   = $clog2(NUM_EXT + 1);

    typedef enum logic [SEL_W-1:0] {
        SRC_FREE_RUN  = 3'd0,
        SRC_COMPARE   = 3'd1,
        SRC_EXT_IRQ0  = 3'd2,
        SRC_T0_CMPA   = 3'd3,
        SRC_T0_OVF    = 3'd4,
        SRC_T1_CMPB   = 3'd5,
        SRC_T1_OVF    = 3'd6,
        SRC_T1_CAPT   = 3'd7
    } trig_src_e;

    typedef struct packed {
        logic auto_en;
        logic conv_en;
        logic busy;
    } gate_ctl_t;

    function automatic logic is_free_run(input logic [SEL_W-1:0] sel);
        return sel == SRC_FREE_RUN;
    endfunction

endpackage

// File: rtl/adc_trig_mux.sv
module adc_trig_mux
    import adc_trig_pkg::*;
#(
    parameter int unsigned N_EXT = NUM_EXT,
    localparam int unsigned SW   = $clog2(N_EXT + 1)
) (
    input  logic [SW-1:0]    sel,
    input  logic [N_EXT-1:0] ext,
    input  logic             done,
    output logic             level
);
    always_comb begin
        level = done;
        for (int i = 0; i < N_EXT; i++) begin
            if (sel == SW'(i + 1)) level = ext[i];
        end
    end
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge
    import adc_trig_pkg::*;
#(
    parameter int unsigned SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] sel,
    input  logic          level,
    output logic          rise
);
    logic prev_q;
    logic was_fr_q;
    logic armed_q;
    logic enter_fr;

    // Entering free run: the remembered level belongs to the old source,
    // so the comparison is masked for this one cycle.
    assign enter_fr = (sel == '0) && !was_fr_q;
    assign rise     = armed_q && level && !prev_q && !enter_fr;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            was_fr_q <= 1'b1;
            armed_q  <= 1'b0;
        end else begin
            prev_q   <= level;
            was_fr_q <= (sel == '0);
            armed_q  <= 1'b1;
        end
    end
endmodule

// File: rtl/adc_trig_gate.sv
module adc_trig_gate
    import adc_trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  gate_ctl_t ctl,
    input  logic      rise,
    output logic      start
);
    logic start_q;

    always_ff @(posedge clk) begin
        if (rst) start_q <= 1'b0;
        else     start_q <= rise && ctl.auto_en && ctl.conv_en && !ctl.busy;
    end

    assign start = start_q;
endmodule

// File: rtl/adc_trig_select.sv
module adc_trig_select
    import adc_trig_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               auto_en,
    input  logic               conv_en,
    input  logic               busy,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic [NUM_EXT-1:0] ext_flags,
    input  logic               conv_done,
    output logic               start_pulse,
    output logic               trig_level
);
    logic      lvl;
    logic      rise;
    gate_ctl_t ctl;

    assign ctl = '{auto_en: auto_en, conv_en: conv_en, busy: busy};

    adc_trig_mux #(.N_EXT(NUM_EXT)) u_mux (
        .sel   (src_sel),
        .ext   (ext_flags),
        .done  (conv_done),
        .level (lvl)
    );

    adc_trig_edge #(.SW(SEL_W)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .sel   (src_sel),
        .level (lvl),
        .rise  (rise)
    );

    adc_trig_gate u_gate (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .rise  (rise),
        .start (start_pulse)
    );

    assign trig_level = lvl;
endmodule

// File: rtl/adc_trig_select_chk.sv
module adc_trig_select_chk (
    input logic       clk,
    input logic       rst,
    input logic       auto_en,
    input logic       conv_en,
    input logic       busy,
    input logic [2:0] src_sel,
    input logic       trig_level,
    input logic       start_pulse
);
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    a_r2_auto_off: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> $past(auto_en));

    a_r6_conv_off: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> $past(conv_en));

    a_r9_busy_drop: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> !$past(busy));

    a_r3_edge_only: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> ($past(trig_level) && !$past(trig_level, 2)));

    a_r5_fr_entry: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> !(($past(src_sel) == 3'd0) && ($past(src_sel, 2) != 3'd0)));
endmodule

bind adc_trig_select adc_trig_select_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .auto_en     (auto_en),
    .conv_en     (conv_en),
    .busy        (busy),
    .src_sel     (src_sel),
    .trig_level  (trig_level),
    .start_pulse (start_pulse)
);

// File: tb/adc_trig_select_tb_top.sv
module adc_trig_select_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       auto_en = 1'b0;
    logic       conv_en = 1'b0;
    logic       busy = 1'b0;
    logic [2:0] src_sel = 3'd0;
    logic [6:0] ext_flags = 7'd0;
    logic       conv_done = 1'b0;
    logic       start_pulse;
    logic       trig_level;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    adc_trig_select dut_i (
        .clk(clk), .rst(rst), .auto_en(auto_en), .conv_en(conv_en),
        .busy(busy), .src_sel(src_sel), .ext_flags(ext_flags),
        .conv_done(conv_done), .start_pulse(start_pulse), .trig_level(trig_level)
    );

    // {auto_en, conv_en, busy, sel[2:0], flags[6:0], done, exp_start, exp_level}
    function automatic logic [15:0] mk(input logic ae, input logic ce, input logic bz,
                                       input logic [2:0] s, input logic [6:0] f,
                                       input logic d, input logic es, input logic el);
        return {ae, ce, bz, s, f, d, es, el};
    endfunction

    localparam int NV = 27;
    localparam logic [15:0] VEC [NV] = '{
        mk(1,1,0,3'd1,7'b0000000,0, 0,0),  // 0
        mk(1,1,0,3'd1,7'b0000001,0, 1,1),  // 1  R3 comparator edge
        mk(1,1,0,3'd1,7'b0000001,0, 0,1),  // 2  R8 one cycle
        mk(1,1,0,3'd1,7'b0000000,0, 0,0),  // 3
        mk(1,1,0,3'd2,7'b0000000,0, 0,0),  // 4
        mk(1,1,0,3'd2,7'b0000010,0, 1,1),  // 5  R1 code 2 -> bit1
        mk(1,1,0,3'd3,7'b0000010,0, 0,0),  // 6  R1 code 3 -> bit2
        mk(1,1,0,3'd4,7'b0001010,0, 1,1),  // 7  R4 switch low->high
        mk(1,0,0,3'd4,7'b0000000,0, 0,0),  // 8
        mk(1,0,0,3'd4,7'b0001000,0, 0,1),  // 9  R6 disabled
        mk(1,1,0,3'd4,7'b0001000,0, 0,1),  // 10 R6 no late start
        mk(0,1,0,3'd4,7'b0000000,0, 0,0),  // 11
        mk(0,1,0,3'd4,7'b0001000,0, 0,1),  // 12 R2 auto off
        mk(1,1,0,3'd5,7'b0000000,0, 0,0),  // 13
        mk(1,1,1,3'd5,7'b0010000,0, 0,1),  // 14 R9 busy
        mk(1,1,0,3'd5,7'b0010000,0, 0,1),  // 15 R9 not queued
        mk(1,1,0,3'd6,7'b0000000,0, 0,0),  // 16
        mk(1,1,0,3'd6,7'b0100000,0, 1,1),  // 17 R1 code 6 -> bit5
        mk(1,1,0,3'd7,7'b0000000,0, 0,0),  // 18
        mk(1,1,0,3'd7,7'b1000000,0, 1,1),  // 19 R1 code 7 -> bit6
        mk(1,1,0,3'd7,7'b0000000,1, 0,0),  // 20
        mk(1,1,0,3'd0,7'b0000000,1, 0,1),  // 21 R5 enter free run
        mk(1,1,0,3'd0,7'b0000000,0, 0,0),  // 22
        mk(1,1,0,3'd0,7'b0000000,1, 1,1),  // 23 R7 free run
        mk(1,1,0,3'd0,7'b0000000,1, 0,1),  // 24 R8
        mk(1,1,0,3'd0,7'b0000000,0, 0,0),  // 25
        mk(1,1,0,3'd0,7'b0000000,1, 1,1)   // 26 R7 back to back
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        step();
        check("R10 reset start", start_pulse, 1'b0);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            logic [15:0] v;
            v = VEC[i];
            {auto_en, conv_en, busy, src_sel, ext_flags, conv_done} = v[15:2];
            step();
            check($sformatf("R1/R3 vec%0d start", i), start_pulse, v[1]);
            check($sformatf("R1 vec%0d level", i), trig_level, v[0]);
        end

        // R10: level high across reset release
        rst = 1'b1; auto_en = 1'b1; conv_en = 1'b1; busy = 1'b0;
        src_sel = 3'd1; ext_flags = 7'b0000001; conv_done = 1'b0;
        step();
        check("R10 start in reset", start_pulse, 1'b0);
        check("R1 level in reset", trig_level, 1'b1);
        rst = 1'b0;
        step();
        check("R10 first cycle", start_pulse, 1'b0);
        step();
        check("R10 second cycle", start_pulse, 1'b0);
        ext_flags = 7'd0;
        step();
        ext_flags = 7'b0000001;
        step();
        check("R3 after reset", start_pulse, 1'b1);
        step();
        check("R8 after reset", start_pulse, 1'b0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule